// File: doc/BRIEF.md
# Bank Ping-Pong Matrix Address Generator

This block produces the address streams for a large matrix that is held in external SDRAM and handled one group at a time. Each new group is written into one bank in plain row order, one burst of columns per write advance. Meanwhile, the group finished just before, which sits in the other bank, is read back. The read pass does not use row order. It walks vertical strips of the matrix a few columns wide, so that a column-oriented stage such as an FFT receives whole columns without buffering an entire bank on chip.

The write side and the read side each have their own advance strobe, and the consumer pulses a strobe when it accepts a burst. The current address stays on the outputs until the next accepted advance. When the last write burst of a group is accepted, both sides swap banks on the same edge. The write pointer moves to the other bank, and the read pointer restarts at the origin of the bank that has just been filled. Flags mark the last burst of a written row, of a read tile and of a group. Matrix size, strip width, tile height and burst length are parameters.

Top module: `bank_pingpong_addr_gen`

## Requirements
- R1: After reset, every address output is zero, `wr_bank` is 0 and `rd_valid` is 0.
- R2: Each accepted `wr_adv` moves `wr_col` up by BURST. At `wr_col` = COLS-BURST, `wr_eor` is 1 and the next advance returns `wr_col` to 0.
- R3: `wr_row` moves up by one after the last burst of a row. `wr_eog` is 1 exactly when `wr_row` = ROWS-1 and `wr_col` = COLS-BURST, and the advance there returns the row to 0.
- R4: `wr_bank` (0 or 1) starts at 0 and inverts on each advance taken while `wr_eog` is 1. It changes at no other time.
- R5: An advance taken while `wr_eog` is 1 sets `rd_valid` to 1, loads `rd_bank` with the bank just written, and puts the read address at row 0, column 0. While `rd_valid` is 1, `rd_bank` differs from `wr_bank`.
- R6: Inside a strip, an accepted `rd_adv` moves `rd_col` up by BURST, up to the last burst of the strip (strip base + TILE_W - BURST). The advance after that returns `rd_col` to the strip base and moves `rd_row` up by one.
- R7: After the last burst of row ROWS-1 in a strip, reading continues at row 0 of the next strip (strip base + TILE_W). `rd_eot` is 1 on the last burst of every row whose index mod TILE_H equals TILE_H-1.
- R8: `rd_eog` is 1 on the last burst of the last row of the last strip. The advance taken there clears `rd_valid` and returns the read address to zero.
- R9: While `rd_valid` is 0, `rd_adv` has no effect: the read address and `rd_bank` stay unchanged, and `rd_eot` and `rd_eog` are 0.
- R10: A bank swap that lands before the read pass is finished, including one in the same cycle as `rd_adv`, restarts reading at the origin of the new read bank. The `rd_adv` in that cycle is dropped.
- R11: While `wr_adv` is 0, the write address and `wr_bank` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_adv | input | 1 | Current write burst accepted |
| rd_adv | input | 1 | Current read burst accepted |
| wr_bank | output | 1 | Bank being written |
| wr_row | output | ROW_W | Write row |
| wr_col | output | COL_W | Write column of burst start |
| wr_eor | output | 1 | Current write burst ends a row |
| wr_eog | output | 1 | Current write burst ends the group |
| rd_valid | output | 1 | A complete group is available for reading |
| rd_bank | output | 1 | Bank being read |
| rd_row | output | ROW_W | Read row |
| rd_col | output | COL_W | Read column of burst start |
| rd_eot | output | 1 | Current read burst ends a tile |
| rd_eog | output | 1 | Current read burst ends the group |

## Verification
The hardest case to reach is a bank swap that arrives while a read pass is only partly done, especially when it falls in the same cycle as a read advance. It only happens when writes outpace reads across a full group. The stimulus first runs sparse writes with dense reads, so that a read pass finishes and then sits idle under further `rd_adv` pulses. It then switches to continuous writes with sparse reads, which forces the swap to land mid-pass. A phase with both strobes held high then places swap and read advance in the same cycle. A reduced matrix keeps each group to a few dozen bursts, so every wrap is reached many times.

// File: rtl/bpag_pkg.sv
package bpag_pkg;
   // width needed to hold values 0 .. n-1, never below one bit
   function automatic int unsigned bits_for(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/bpag_wrap_ctr.sv
module bpag_wrap_ctr
   import bpag_pkg::*;
#(
   parameter int unsigned LIMIT = 8,
   parameter int unsigned STEP  = 1,
   parameter int unsigned W     = bits_for(LIMIT)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] val,
   output logic         at_last
);
   localparam logic [W-1:0] LAST_V = W'(LIMIT - STEP);
   localparam logic [W-1:0] STEP_V = W'(STEP);

   generate
      if ((LIMIT % STEP) != 0 || STEP == 0) begin : g_bad
         $error("wrap counter limit must be a nonzero multiple of its step");
      end
   endgenerate

   assign at_last = (val == LAST_V);

   always_ff @(posedge clk) begin
      if (!rst_n || clr)  val <= '0;
      else if (inc)       val <= at_last ? '0 : val + STEP_V;
   end

   // R2 R6
   val_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (val <= LAST_V) && ((val % STEP_V) == '0));
endmodule

// File: rtl/bpag_wr_seq.sv
module bpag_wr_seq
   import bpag_pkg::*;
#(
   parameter int unsigned ROWS  = 4000,
   parameter int unsigned COLS  = 1024,
   parameter int unsigned BURST = 8,
   parameter int unsigned ROW_W = bits_for(ROWS),
   parameter int unsigned COL_W = bits_for(COLS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic             bank,
   output logic [ROW_W-1:0] row,
   output logic [COL_W-1:0] col,
   output logic             eor,
   output logic             eog
);
   logic col_last, row_last;

   bpag_wrap_ctr #(.LIMIT(COLS), .STEP(BURST), .W(COL_W)) col_ctr_i (
      .clk(clk), .rst_n(rst_n), .clr(1'b0), .inc(adv),
      .val(col), .at_last(col_last));

   bpag_wrap_ctr #(.LIMIT(ROWS), .STEP(1), .W(ROW_W)) row_ctr_i (
      .clk(clk), .rst_n(rst_n), .clr(1'b0), .inc(adv && col_last),
      .val(row), .at_last(row_last));

   assign eor = col_last;
   assign eog = col_last && row_last;

   always_ff @(posedge clk) begin
      if (!rst_n)          bank <= 1'b0;
      else if (adv && eog) bank <= ~bank;
   end

   // R4
   wr_bank_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bank) |-> $past(adv && eog));

   // R11
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(row) && $stable(col) && $stable(bank));
endmodule

// File: rtl/bpag_rd_seq.sv
module bpag_rd_seq
   import bpag_pkg::*;
#(
   parameter int unsigned ROWS   = 4000,
   parameter int unsigned COLS   = 1024,
   parameter int unsigned TILE_W = 64,
   parameter int unsigned TILE_H = 16,
   parameter int unsigned BURST  = 8,
   parameter int unsigned ROW_W  = bits_for(ROWS),
   parameter int unsigned COL_W  = bits_for(COLS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             swap,
   input  logic             fill_bank,
   output logic             valid,
   output logic             bank,
   output logic [ROW_W-1:0] row,
   output logic [COL_W-1:0] col,
   output logic             eot,
   output logic             eog
);
   localparam int unsigned CIN_W = bits_for(TILE_W);
   localparam int unsigned TR_W  = bits_for(TILE_H);

   logic [CIN_W-1:0] cin;
   logic [TR_W-1:0]  trow;
   logic [COL_W-1:0] strip;
   logic cin_last, trow_last, row_last, strip_last, step, grp_end;

   assign step    = adv && valid && !swap;
   assign grp_end = cin_last && row_last && strip_last;

   bpag_wrap_ctr #(.LIMIT(TILE_W), .STEP(BURST), .W(CIN_W)) cin_ctr_i (
      .clk(clk), .rst_n(rst_n), .clr(swap), .inc(step),
      .val(cin), .at_last(cin_last));

   bpag_wrap_ctr #(.LIMIT(TILE_H), .STEP(1), .W(TR_W)) trow_ctr_i (
      .clk(clk), .rst_n(rst_n), .clr(swap), .inc(step && cin_last),
      .val(trow), .at_last(trow_last));

   bpag_wrap_ctr #(.LIMIT(ROWS), .STEP(1), .W(ROW_W)) row_ctr_i (
      .clk(clk), .rst_n(rst_n), .clr(swap), .inc(step && cin_last),
      .val(row), .at_last(row_last));

   bpag_wrap_ctr #(.LIMIT(COLS), .STEP(TILE_W), .W(COL_W)) strip_ctr_i (
      .clk(clk), .rst_n(rst_n), .clr(swap), .inc(step && cin_last && row_last),
      .val(strip), .at_last(strip_last));

   assign col = strip + COL_W'(cin);
   assign eot = valid && cin_last && trow_last;
   assign eog = valid && grp_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         bank  <= 1'b0;
      end else if (swap) begin
         valid <= 1'b1;
         bank  <= fill_bank;
      end else if (step && grp_end) begin
         valid <= 1'b0;
      end
   end

   // R5 R10
   rd_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      swap |=> valid && (row == '0) && (col == '0));

   // R8
   rd_valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(valid) |-> $past(adv && eog));

   // R9
   rd_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid && !swap) |=> $stable(row) && $stable(col) && $stable(bank));
endmodule

// File: rtl/bank_pingpong_addr_gen.sv
module bank_pingpong_addr_gen
   import bpag_pkg::*;
#(
   parameter int unsigned ROWS   = 4000,
   parameter int unsigned COLS   = 1024,
   parameter int unsigned TILE_W = 64,
   parameter int unsigned TILE_H = 16,
   parameter int unsigned BURST  = 8,
   localparam int unsigned ROW_W = bits_for(ROWS),
   localparam int unsigned COL_W = bits_for(COLS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_adv,
   input  logic             rd_adv,
   output logic             wr_bank,
   output logic [ROW_W-1:0] wr_row,
   output logic [COL_W-1:0] wr_col,
   output logic             wr_eor,
   output logic             wr_eog,
   output logic             rd_valid,
   output logic             rd_bank,
   output logic [ROW_W-1:0] rd_row,
   output logic [COL_W-1:0] rd_col,
   output logic             rd_eot,
   output logic             rd_eog
);
   generate
      if ((COLS % TILE_W) != 0) begin : g_bad_strip
         $error("COLS must be a multiple of TILE_W");
      end
      if ((TILE_W % BURST) != 0) begin : g_bad_burst
         $error("TILE_W must be a multiple of BURST");
      end
      if ((ROWS % TILE_H) != 0) begin : g_bad_tile
         $error("ROWS must be a multiple of TILE_H");
      end
   endgenerate

   logic swap;

   bpag_wr_seq #(.ROWS(ROWS), .COLS(COLS), .BURST(BURST),
                 .ROW_W(ROW_W), .COL_W(COL_W)) wr_i (
      .clk(clk), .rst_n(rst_n), .adv(wr_adv),
      .bank(wr_bank), .row(wr_row), .col(wr_col),
      .eor(wr_eor), .eog(wr_eog));

   assign swap = wr_adv && wr_eog;

   bpag_rd_seq #(.ROWS(ROWS), .COLS(COLS), .TILE_W(TILE_W), .TILE_H(TILE_H),
                 .BURST(BURST), .ROW_W(ROW_W), .COL_W(COL_W)) rd_i (
      .clk(clk), .rst_n(rst_n), .adv(rd_adv), .swap(swap),
      .fill_bank(wr_bank), .valid(rd_valid), .bank(rd_bank),
      .row(rd_row), .col(rd_col), .eot(rd_eot), .eog(rd_eog));

   // R5
   bank_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (rd_bank != wr_bank));
endmodule

// File: tb/bank_pingpong_addr_gen_tb_top.sv
module bank_pingpong_addr_gen_tb_top;
   import bpag_pkg::*;

   localparam int ROWS = 8, COLS = 32, TW = 16, TH = 4, B = 8;
   localparam int ROW_W = bits_for(ROWS);
   localparam int COL_W = bits_for(COLS);
   localparam int CLK_PERIOD = 10;
   localparam int WB = COLS / B;
   localparam int WLAST = ROWS * WB - 1;
   localparam int RW = TW / B;
   localparam int PERSTRIP = ROWS * RW;
   localparam int RLAST = (COLS / TW) * PERSTRIP - 1;

   typedef struct {
      int    bank, row, col;
      bit    f1, f2, v;
      string tag;
   } item_t;

   logic clk = 1'b0, rst_n = 1'b0, wr_adv = 1'b0, rd_adv = 1'b0;
   logic wr_bank, wr_eor, wr_eog, rd_valid, rd_bank, rd_eot, rd_eog;
   logic [ROW_W-1:0] wr_row, rd_row;
   logic [COL_W-1:0] wr_col, rd_col;

   int total = 0, bad = 0;
   bit running = 0, done = 0;
   string ptag = "R1";
   item_t wq[$], rq[$];

   // reference model state
   int wk = 0, wbank_m = 0, rk = 0, rbank_m = 0;
   bit rvalid_m = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bank_pingpong_addr_gen #(.ROWS(ROWS), .COLS(COLS), .TILE_W(TW),
                            .TILE_H(TH), .BURST(B)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_adv(wr_adv), .rd_adv(rd_adv),
      .wr_bank(wr_bank), .wr_row(wr_row), .wr_col(wr_col),
      .wr_eor(wr_eor), .wr_eog(wr_eog), .rd_valid(rd_valid),
      .rd_bank(rd_bank), .rd_row(rd_row), .rd_col(rd_col),
      .rd_eot(rd_eot), .rd_eog(rd_eog));

   task automatic chk(input string req, input string ctx, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s (%s) t=%0t actual=%0d expected=%0d", req, ctx, $time, act, exp);
      end
   endtask

   function automatic item_t wr_exp();
      item_t it;
      it.bank = wbank_m;
      it.row  = wk / WB;
      it.col  = (wk % WB) * B;
      it.f1   = ((wk % WB) == WB - 1);
      it.f2   = (wk == WLAST);
      it.v    = 1'b1;
      it.tag  = ptag;
      return it;
   endfunction

   function automatic item_t rd_exp();
      item_t it;
      int strip = rk / PERSTRIP;
      int r = rk % PERSTRIP;
      int ci = r % RW;
      it.bank = rbank_m;
      it.row  = r / RW;
      it.col  = strip * TW + ci * B;
      it.f1   = rvalid_m && (ci == RW - 1) && ((it.row % TH) == TH - 1);
      it.f2   = rvalid_m && (rk == RLAST);
      it.v    = rvalid_m;
      it.tag  = ptag;
      return it;
   endfunction

   // driver: one cycle of stimulus, expected items pushed, model advanced
   task automatic step(input bit w, input bit r);
      bit swap;
      @(posedge clk);
      #1;
      wr_adv = w;
      rd_adv = r;
      wq.push_back(wr_exp());
      rq.push_back(rd_exp());
      swap = w && (wk == WLAST);
      if (swap) begin
         rbank_m  = wbank_m;
         rk       = 0;
         rvalid_m = 1'b1;
      end else if (r && rvalid_m) begin
         if (rk == RLAST) begin
            rk = 0;
            rvalid_m = 1'b0;
         end else rk++;
      end
      if (w) begin
         if (wk == WLAST) begin
            wk = 0;
            wbank_m ^= 1;
         end else wk++;
      end
   endtask

   // monitor: compares ports against popped expectations
   always @(negedge clk) begin
      item_t e;
      if (running && wq.size() > 0) begin
         e = wq.pop_front();
         chk("R2", e.tag, int'(wr_col), e.col);
         chk("R2", e.tag, int'(wr_eor), int'(e.f1));
         chk("R3", e.tag, int'(wr_row), e.row);
         chk("R3", e.tag, int'(wr_eog), int'(e.f2));
         chk("R4", e.tag, int'(wr_bank), e.bank);
      end
      if (running && rq.size() > 0) begin
         e = rq.pop_front();
         chk("R5", e.tag, int'(rd_valid), int'(e.v));
         chk("R5", e.tag, int'(rd_bank), e.bank);
         chk("R6", e.tag, int'(rd_col), e.col);
         chk("R7", e.tag, int'(rd_row), e.row);
         chk("R7", e.tag, int'(rd_eot), int'(e.f1));
         chk("R8", e.tag, int'(rd_eog), int'(e.f2));
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "reset", int'(wr_row) + int'(wr_col) + int'(rd_row) + int'(rd_col), 0);
      chk("R1", "reset", int'(wr_bank), 0);
      chk("R1", "reset", int'(rd_valid), 0);
      running = 1;
      // R9 R11: gapped writes, read strobes before any group exists
      ptag = "R9/R11";
      for (int i = 0; i < 50; i++) step(i % 3 != 0, 1'b1);
      // R8 R9: reads outrun writes, then idle read strobes
      ptag = "R8/R9";
      for (int i = 0; i < 120; i++) step(i % 4 == 0, 1'b1);
      // R10: writes outrun reads, swap lands mid-pass
      ptag = "R10";
      for (int i = 0; i < 70; i++) step(1'b1, i % 4 == 0);
      // R10: both strobes held, swap coincides with read advance
      ptag = "R6/R7/R10";
      for (int i = 0; i < 200; i++) step(1'b1, 1'b1);
      ptag = "R11";
      for (int i = 0; i < 6; i++) step(1'b0, 1'b0);
      @(posedge clk);
      @(posedge clk);
      running = 0;
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired t=%0t actual=hung expected=finished", $time);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule